// File: doc/BRIEF.md
# Reset strap configuration latch

This block turns a shared memory-address bus into a set of power-on configuration straps. While the chip reset is held, the block drives an enable for weak pull-ups on the eight strap lines, so any line without an external pull-down reads as one. On the first clock edge after reset is released, it copies the bus into a configuration register. It then keeps that register, and the control outputs decoded from it, until the next reset, whatever the bus does afterwards.

Three fields control hardware. A two-bit code picks the host CPU bus type, which is given both as a code and as a one-hot select. One bit selects the function of a shared pin: read strobe for external data transceivers, or panel supply enable. One bit selects whether the input clock is doubled. This block exports that choice only as a registered select and generates no clock. The remaining bits are kept but control nothing. The whole register can be read through an indexed extension-register port at index 01h. It is read-only, and writes to it are dropped.

A capture state machine sequences the work. `CAP_RESET` holds the pull-ups on and waits for reset to be released. The transition `CAP_RESET -> CAP_DECODE` loads the register. The transition `CAP_DECODE -> CAP_RUN` loads the decoded outputs. `CAP_RUN` holds everything steady. Any assertion of reset returns the machine to `CAP_RESET` at once.

Top module: `strap_cfg_latch`

## Requirements
- R1: `strap_pullup_en` is 1 whenever `sys_reset` is 1, and it stays 1 up to and including the first rising clock edge after reset is released. From the following cycle onward it is 0 until reset is asserted again.
- R2: The configuration register takes the value of `strap_in` at the first rising clock edge after reset is released. Changes on `strap_in` after that edge have no effect on the register or on any decoded output until the next reset.
- R3: Two clock edges after reset is released, `host_bus_code` equals captured bits 1:0, with 00 = PI bus, 01 = MC bus, 10 = local bus and 11 = ISA bus. `host_bus_sel` is one-hot with bit n set for code n.
- R4: Two clock edges after reset is released, `pin_vdd_mode` equals captured bit 3. A value of 0 means external transceivers are present and the shared pin is a read strobe. A value of 1 means there are no external transceivers and the pin is a panel supply enable.
- R5: Two clock edges after reset is released, `clk_dbl_bypass` equals captured bit 4. A value of 0 means clock doubling is used (14.318 MHz reference). A value of 1 means the input clock (25 to 50 MHz) passes without doubling.
- R6: A read strobe `xr_rd` with `xr_index` = 01h produces, on the next cycle, `xr_hit` = 1 and `xr_rdata` equal to all eight captured bits in place. This includes reserved bit 2 and the spare bits 7:5.
- R7: In a cycle that follows no read of index 01h, and during reset, `xr_hit` and `xr_rdata` are 0.
- R8: A write strobe `xr_wr` to index 01h is ignored: a later read returns the captured value, and the decoded outputs do not change.
- R9: Asserting reset again turns the pull-ups back on. The next release captures the new bus value, and that value replaces the previous one in the register and in all decoded outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| sys_reset | input | 1 | Chip reset, active high, asserted asynchronously |
| strap_in | input | 8 | Shared memory-address bus sampled as straps |
| strap_pullup_en | output | 1 | Enable for weak pull-ups on the strap lines |
| xr_index | input | 8 | Currently selected extension-register index |
| xr_rd | input | 1 | Extension data read strobe |
| xr_wr | input | 1 | Extension data write strobe |
| xr_wdata | input | 8 | Extension write data (dropped for this register) |
| xr_rdata | output | 8 | Read data, valid the cycle after a read |
| xr_hit | output | 1 | This block answered the previous read |
| host_bus_code | output | 2 | Decoded CPU bus type code |
| host_bus_sel | output | 4 | One-hot CPU bus type select |
| pin_vdd_mode | output | 1 | Shared pin function select |
| clk_dbl_bypass | output | 1 | Clock doubler bypass select |

## Verification
On every cycle, the bound assertions check the following:
- pull-ups are on during reset and off once the machine runs;
- the register is frozen while running, and a write cannot put its data there;
- every decoded output matches the captured bits, and the bus select is one-hot;
- every read response follows its strobe in the next cycle.

Only the bench's scenarios can show the rest:
- the register holds the bus value from the capture edge itself, and not a value seen earlier in reset;
- a changed bus after release is really ignored;
- across several resets with different straps, each bus type code, both pin modes and both doubler settings appear at the outputs.

// File: rtl/strap_cfg_pkg.sv
`timescale 1ns/1ps
package strap_cfg_pkg;

    // Width of the strap bus and of the extension index
    localparam int STRAP_W = 8;
    localparam int IDX_W   = 8;

    // Field positions that the decoded outputs depend on
    localparam int BUS_LSB  = 0;
    localparam int BUS_W    = 2;
    localparam int XCVR_BIT = 3;
    localparam int DBL_BIT  = 4;

    // Host bus type codes
    typedef enum logic [BUS_W-1:0] {
        HBUS_PI    = 2'b00,
        HBUS_MC    = 2'b01,
        HBUS_LOCAL = 2'b10,
        HBUS_ISA   = 2'b11
    } host_bus_e;

    // Capture sequencer states
    typedef enum logic [1:0] {
        CAP_RESET  = 2'b00,
        CAP_DECODE = 2'b01,
        CAP_RUN    = 2'b10
    } cap_state_e;

endpackage

// File: rtl/strap_capture_fsm.sv
`timescale 1ns/1ps
module strap_capture_fsm
    import strap_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       sys_reset,
    output cap_state_e state,
    output logic       pullup_en,
    output logic       cap_en,
    output logic       dec_en
);

    cap_state_e state_nxt;

    // State register: reset forces the waiting state immediately
    always_ff @(posedge clk or posedge sys_reset) begin
        if (sys_reset) begin
            state <= CAP_RESET;
        end else begin
            state <= state_nxt;
        end
    end

    // Transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            CAP_RESET:  state_nxt = CAP_DECODE;
            CAP_DECODE: state_nxt = CAP_RUN;
            CAP_RUN:    state_nxt = CAP_RUN;
            default:    state_nxt = CAP_RESET;
        endcase
    end

    // Outputs
    always_comb begin
        pullup_en = 1'b0;
        cap_en    = 1'b0;
        dec_en    = 1'b0;
        unique case (state)
            CAP_RESET: begin
                pullup_en = 1'b1;
                cap_en    = ~sys_reset;
            end
            CAP_DECODE: begin
                dec_en    = 1'b1;
            end
            CAP_RUN: begin
                pullup_en = 1'b0;
            end
            default: begin
                pullup_en = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/strap_decode.sv
`timescale 1ns/1ps
module strap_decode
    import strap_cfg_pkg::*;
#(
    parameter int CODE_W = BUS_W
) (
    input  logic                  clk,
    input  logic                  dec_en,
    input  logic [CODE_W-1:0]     bus_bits,
    input  logic                  xcvr_bit,
    input  logic                  dbl_bit,
    output logic [CODE_W-1:0]     bus_code,
    output logic [(1<<CODE_W)-1:0] bus_sel,
    output logic                  pin_vdd_mode,
    output logic                  dbl_bypass
);

    localparam int NUM_BUS = 1 << CODE_W;

    // Decoded values load once per reset and then hold; no constant reset
    always_ff @(posedge clk) begin
        if (dec_en) begin
            bus_code     <= bus_bits;
            pin_vdd_mode <= xcvr_bit;
            dbl_bypass   <= dbl_bit;
        end
    end

    // One-hot bus type select
    for (genvar g = 0; g < NUM_BUS; g++) begin : g_bus_sel
        assign bus_sel[g] = (bus_code == CODE_W'(g));
    end

endmodule

// File: rtl/xreg_readback.sv
`timescale 1ns/1ps
module xreg_readback
    import strap_cfg_pkg::*;
#(
    parameter int             DATA_W   = STRAP_W,
    parameter int             INDEX_W  = IDX_W,
    parameter logic [IDX_W-1:0] MY_INDEX = 8'h01
) (
    input  logic               clk,
    input  logic               sys_reset,
    input  logic [INDEX_W-1:0] xr_index,
    input  logic               xr_rd,
    input  logic [DATA_W-1:0]  cfg,
    output logic [DATA_W-1:0]  rdata,
    output logic               hit
);

    logic sel_rd;
    assign sel_rd = xr_rd && (xr_index == INDEX_W'(MY_INDEX));

    always_ff @(posedge clk or posedge sys_reset) begin
        if (sys_reset) begin
            hit   <= 1'b0;
            rdata <= '0;
        end else if (sel_rd) begin
            hit   <= 1'b1;
            rdata <= cfg;
        end else begin
            hit   <= 1'b0;
            rdata <= '0;
        end
    end

endmodule

// File: rtl/strap_cfg_latch.sv
`timescale 1ns/1ps
module strap_cfg_latch
    import strap_cfg_pkg::*;
#(
    parameter int               SW        = STRAP_W,
    parameter int               XW        = IDX_W,
    parameter logic [IDX_W-1:0] CFG_INDEX = 8'h01
) (
    input  logic          clk,
    input  logic          sys_reset,
    input  logic [SW-1:0] strap_in,
    output logic          strap_pullup_en,
    input  logic [XW-1:0] xr_index,
    input  logic          xr_rd,
    input  logic          xr_wr,
    input  logic [SW-1:0] xr_wdata,
    output logic [SW-1:0] xr_rdata,
    output logic          xr_hit,
    output logic [1:0]    host_bus_code,
    output logic [3:0]    host_bus_sel,
    output logic          pin_vdd_mode,
    output logic          clk_dbl_bypass
);

    localparam int NUM_BUS = 1 << BUS_W;

    cap_state_e    cap_state;
    logic          cap_en;
    logic          dec_en;
    logic [SW-1:0] cfg_q;

    strap_capture_fsm u_fsm (
        .clk       (clk),
        .sys_reset (sys_reset),
        .state     (cap_state),
        .pullup_en (strap_pullup_en),
        .cap_en    (cap_en),
        .dec_en    (dec_en)
    );

    // Configuration register: loads only at the capture edge
    always_ff @(posedge clk) begin
        if (cap_en) begin
            cfg_q <= strap_in;
        end
    end

    logic [BUS_W-1:0]   bus_code_w;
    logic [NUM_BUS-1:0] bus_sel_w;

    strap_decode #(.CODE_W(BUS_W)) u_dec (
        .clk          (clk),
        .dec_en       (dec_en),
        .bus_bits     (cfg_q[BUS_LSB +: BUS_W]),
        .xcvr_bit     (cfg_q[XCVR_BIT]),
        .dbl_bit      (cfg_q[DBL_BIT]),
        .bus_code     (bus_code_w),
        .bus_sel      (bus_sel_w),
        .pin_vdd_mode (pin_vdd_mode),
        .dbl_bypass   (clk_dbl_bypass)
    );

    assign host_bus_code = bus_code_w;
    assign host_bus_sel  = bus_sel_w;

    xreg_readback #(.DATA_W(SW), .INDEX_W(XW), .MY_INDEX(CFG_INDEX)) u_rb (
        .clk       (clk),
        .sys_reset (sys_reset),
        .xr_index  (xr_index),
        .xr_rd     (xr_rd),
        .cfg       (cfg_q),
        .rdata     (xr_rdata),
        .hit       (xr_hit)
    );

endmodule

// File: rtl/strap_cfg_latch_chk.sv
`timescale 1ns/1ps
module strap_cfg_latch_chk
    import strap_cfg_pkg::*;
(
    input logic       clk,
    input logic       sys_reset,
    input cap_state_e st,
    input logic [7:0] cfg_q,
    input logic       strap_pullup_en,
    input logic [7:0] xr_index,
    input logic       xr_rd,
    input logic       xr_wr,
    input logic [7:0] xr_wdata,
    input logic [7:0] xr_rdata,
    input logic       xr_hit,
    input logic [1:0] host_bus_code,
    input logic [3:0] host_bus_sel,
    input logic       pin_vdd_mode,
    input logic       clk_dbl_bypass
);

    AST_PULLUP_IN_RESET: assert property (@(posedge clk)
        sys_reset |-> strap_pullup_en); // R1

    AST_PULLUP_OFF_RUN: assert property (@(posedge clk) disable iff (sys_reset)
        (st == CAP_RUN) |-> !strap_pullup_en); // R1

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (sys_reset)
        (st == CAP_RUN && $past(st) == CAP_RUN) |-> $stable(cfg_q)); // R2

    AST_BUS_CODE: assert property (@(posedge clk) disable iff (sys_reset)
        (st == CAP_RUN) |-> (host_bus_code == cfg_q[1:0])); // R3

    AST_BUS_ONEHOT: assert property (@(posedge clk) disable iff (sys_reset)
        (st == CAP_RUN) |-> ($countones(host_bus_sel) == 1 && host_bus_sel[host_bus_code])); // R3

    AST_PIN_MODE: assert property (@(posedge clk) disable iff (sys_reset)
        (st == CAP_RUN) |-> (pin_vdd_mode == cfg_q[3])); // R4

    AST_DBL_SEL: assert property (@(posedge clk) disable iff (sys_reset)
        (st == CAP_RUN) |-> (clk_dbl_bypass == cfg_q[4])); // R5

    AST_READ_HIT: assert property (@(posedge clk) disable iff (sys_reset)
        ($past(!sys_reset) && $past(xr_rd && xr_index == 8'h01))
        |-> (xr_hit && xr_rdata == $past(cfg_q))); // R6

    AST_READ_MISS: assert property (@(posedge clk) disable iff (sys_reset)
        $past(!(xr_rd && xr_index == 8'h01)) |-> (!xr_hit && xr_rdata == 8'h00)); // R7

    AST_WRITE_DROPPED: assert property (@(posedge clk) disable iff (sys_reset)
        (st == CAP_RUN && xr_wr && xr_index == 8'h01 && xr_wdata != cfg_q)
        |=> (cfg_q != $past(xr_wdata))); // R8

endmodule

bind strap_cfg_latch strap_cfg_latch_chk u_chk (
    .clk             (clk),
    .sys_reset       (sys_reset),
    .st              (cap_state),
    .cfg_q           (cfg_q),
    .strap_pullup_en (strap_pullup_en),
    .xr_index        (xr_index),
    .xr_rd           (xr_rd),
    .xr_wr           (xr_wr),
    .xr_wdata        (xr_wdata),
    .xr_rdata        (xr_rdata),
    .xr_hit          (xr_hit),
    .host_bus_code   (host_bus_code),
    .host_bus_sel    (host_bus_sel),
    .pin_vdd_mode    (pin_vdd_mode),
    .clk_dbl_bypass  (clk_dbl_bypass)
);

// File: tb/strap_cfg_latch_test.sv
`timescale 1ns/1ps
module strap_cfg_latch_test;

    logic       clk = 1'b0;
    logic       sys_reset = 1'b0;
    logic [7:0] strap_bus = 8'hFF;
    logic [7:0] xr_index = 8'h00;
    logic       xr_rd = 1'b0;
    logic       xr_wr = 1'b0;
    logic [7:0] xr_wdata = 8'h00;
    logic       strap_pullup_en;
    logic [7:0] xr_rdata;
    logic       xr_hit;
    logic [1:0] host_bus_code;
    logic [3:0] host_bus_sel;
    logic       pin_vdd_mode;
    logic       clk_dbl_bypass;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    strap_cfg_latch uut (
        .clk             (clk),
        .sys_reset       (sys_reset),
        .strap_in        (strap_bus),
        .strap_pullup_en (strap_pullup_en),
        .xr_index        (xr_index),
        .xr_rd           (xr_rd),
        .xr_wr           (xr_wr),
        .xr_wdata        (xr_wdata),
        .xr_rdata        (xr_rdata),
        .xr_hit          (xr_hit),
        .host_bus_code   (host_bus_code),
        .host_bus_sel    (host_bus_sel),
        .pin_vdd_mode    (pin_vdd_mode),
        .clk_dbl_bypass  (clk_dbl_bypass)
    );

    task automatic check(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model, advanced at each rising edge
    logic [7:0] m_cfg = 8'h00;
    int         m_phase = 0;   // 0 waiting for release, 1 captured, 2 decoded
    bit         m_hit = 1'b0;
    logic [7:0] m_rdata = 8'h00;

    always @(posedge clk) begin
        if (sys_reset) begin
            m_phase = 0;
            m_hit   = 1'b0;
            m_rdata = 8'h00;
        end else begin
            if (xr_rd && xr_index == 8'h01) begin
                m_hit   = 1'b1;
                m_rdata = m_cfg;
            end else begin
                m_hit   = 1'b0;
                m_rdata = 8'h00;
            end
            if (m_phase == 0) begin
                m_cfg   = strap_bus;
                m_phase = 1;
            end else if (m_phase == 1) begin
                m_phase = 2;
            end
        end
    end

    // Per-cycle comparison, a quarter period after each rising edge
    always @(posedge clk) begin
        #5;
        if (!done) begin
            check("R1 pullup", int'(strap_pullup_en), int'(sys_reset || m_phase == 0));
            check("R6/R7 hit", int'(xr_hit), int'(m_hit));
            check("R6/R7 rdata", int'(xr_rdata), int'(m_rdata));
            if (m_phase == 2 && !sys_reset) begin
                check("R3 bus code", int'(host_bus_code), int'(m_cfg[1:0]));
                check("R3 bus sel", int'(host_bus_sel), int'(4'b0001 << m_cfg[1:0]));
                check("R4 pin mode", int'(pin_vdd_mode), int'(m_cfg[3]));
                check("R5 doubler", int'(clk_dbl_bypass), int'(m_cfg[4]));
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog expired actual=%0d expected<=20000", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic do_read(logic [7:0] idx, bit exp_hit, logic [7:0] exp_d, string tag);
        @(negedge clk);
        xr_index = idx;
        xr_rd    = 1'b1;
        @(posedge clk);
        #5;
        check({tag, " hit"}, int'(xr_hit), int'(exp_hit));
        check({tag, " data"}, int'(xr_rdata), int'(exp_d));
        @(negedge clk);
        xr_rd = 1'b0;
    endtask

    task automatic do_write(logic [7:0] idx, logic [7:0] d);
        @(negedge clk);
        xr_index = idx;
        xr_wdata = d;
        xr_wr    = 1'b1;
        @(negedge clk);
        xr_wr = 1'b0;
    endtask

    // Hold reset with an early bus value, then switch to the final strap and release
    task automatic reset_cycle(logic [7:0] early, logic [7:0] final_v, string tag);
        @(negedge clk);
        sys_reset = 1'b1;
        strap_bus = early;
        repeat (3) @(posedge clk);
        #5;
        check({tag, " pullup on in reset"}, int'(strap_pullup_en), 1);
        check({tag, " no hit in reset"}, int'(xr_hit), 0);
        @(negedge clk);
        strap_bus = final_v;
        @(negedge clk);
        sys_reset = 1'b0;
        repeat (3) @(posedge clk);
        #5;
        check({tag, " pullup off"}, int'(strap_pullup_en), 0);
        check("R3 code after release", int'(host_bus_code), int'(final_v[1:0]));
        check("R3 one-hot after release", int'(host_bus_sel), int'(4'b0001 << final_v[1:0]));
        check("R4 pin after release", int'(pin_vdd_mode), int'(final_v[3]));
        check("R5 doubler after release", int'(clk_dbl_bypass), int'(final_v[4]));
        do_read(8'h01, 1'b1, final_v, {tag, " readback"});
    endtask

    initial begin
        #2 sys_reset = 1'b1;
        repeat (2) @(posedge clk);
        #5;
        check("R1 pullup at start", int'(strap_pullup_en), 1);
        check("R7 hit at start", int'(xr_hit), 0);

        // First release: PI bus, transceivers present, doubling on, reserved bit set
        @(negedge clk);
        strap_bus = 8'hA4;
        @(negedge clk);
        sys_reset = 1'b0;
        @(posedge clk);
        #5;
        check("R1 pullup off after capture edge", int'(strap_pullup_en), 0);
        repeat (2) @(posedge clk);
        #5;
        check("R3 PI code", int'(host_bus_code), 0);
        check("R3 PI select", int'(host_bus_sel), 1);
        check("R4 read strobe mode", int'(pin_vdd_mode), 0);
        check("R5 doubling on", int'(clk_dbl_bypass), 0);
        do_read(8'h01, 1'b1, 8'hA4, "R6 all bits");

        // Other indices do not answer
        do_read(8'h02, 1'b0, 8'h00, "R7 index 02");
        do_read(8'h00, 1'b0, 8'h00, "R7 index 00");
        do_read(8'h81, 1'b0, 8'h00, "R7 index 81");

        // Bus changes after capture are ignored
        @(negedge clk);
        strap_bus = 8'h5B;
        repeat (4) @(posedge clk);
        #5;
        check("R2 code holds", int'(host_bus_code), 0);
        check("R2 doubler holds", int'(clk_dbl_bypass), 0);
        do_read(8'h01, 1'b1, 8'hA4, "R2 register holds");

        // Write to the register is dropped
        do_write(8'h01, 8'h3C);
        do_write(8'h01, 8'hFF);
        @(posedge clk);
        #5;
        check("R8 code after write", int'(host_bus_code), 0);
        check("R8 pin after write", int'(pin_vdd_mode), 0);
        do_read(8'h01, 1'b1, 8'hA4, "R8 read after write");

        // New resets with new straps
        reset_cycle(8'hFF, 8'h19, "R9 MC");
        reset_cycle(8'h00, 8'hE2, "R9 local");
        reset_cycle(8'h07, 8'h1F, "R9 ISA");
        reset_cycle(8'hFF, 8'h00, "R9 all zero");
        reset_cycle(8'h00, 8'hFF, "R9 all one");

        repeat (4) @(posedge clk);
        #5;
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule